// File: doc/BRIEF.md
# Interval Timer with Oscillator-Settling Wait

This block is a free-running binary counter that runs on the main oscillator clock. A selectable low-order slice of the counter defines a timing interval, and the block raises a one-cycle interrupt request each time that interval elapses. Software chooses the interval with a 3-bit mode code and can restart the count through a clear bit in the same write. When the watchdog enable is set and software lets the interval expire without a clear, the block also emits a one-cycle reset request.

The same counter times the settling delay after the chip leaves stop mode. While stopped, the oscillator is assumed idle and the counter is frozen. On a release, the counter restarts from zero and the CPU stays held until the settling interval has elapsed. A release caused by reset always waits a fixed interval. A release caused by an interrupt waits for the interval currently chosen by the mode code.

Top module: `interval_timer`

## Requirements
- R1: After reset, cpu_hold, tick_irq and wdt_rst are low, watchdog is disabled and mode code 000 is in effect, so the first tick_irq appears 2^SH_M0 clocks after reset release.
- R2: The mode codes 000, 011, 101 and 111 select intervals of 2^SH_M0, 2^SH_M3, 2^SH_M5 and 2^SH_M7 clocks. tick_irq is a one-clock pulse that repeats at the selected interval.
- R3: A write of any other mode code (001, 010, 100, 110) leaves the previous interval selection unchanged.
- R4: A write with cfg_clr high while running zeroes the counter and suppresses any tick due on that clock edge. The next tick_irq then arrives exactly one selected interval after that edge.
- R5: With the watchdog enable (cfg_wdog) written to 1, every tick_irq is accompanied by a one-clock wdt_rst. With the enable at 0, wdt_rst stays low.
- R6: stop_req while running enters stop mode on the next edge. In stop mode cpu_hold is high, the counter is frozen, and no tick_irq or wdt_rst is raised.
- R7: A release by wake_rst holds the CPU for 2^SH_RST clocks after the release edge, whatever mode code is selected.
- R8: A release by wake_irq holds the CPU for the currently selected interval after the release edge.
- R9: If wake_rst and wake_irq arrive together, the reset release and its fixed interval take effect.
- R10: No tick_irq or wdt_rst is raised while the CPU is held. After a settling wait ends, the counter keeps running from where the wait left it, so the first tick comes at the next multiple of the selected interval counted from the release edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Interval mode code |
| cfg_wdog | input | 1 | Watchdog enable written with the strobe |
| cfg_clr | input | 1 | Counter clear written with the strobe |
| stop_req | input | 1 | Enter stop mode |
| wake_rst | input | 1 | Release stop mode, reset source |
| wake_irq | input | 1 | Release stop mode, interrupt source |
| cpu_hold | output | 1 | CPU held (stopped or settling) |
| tick_irq | output | 1 | Interval interrupt request pulse |
| wdt_rst | output | 1 | Watchdog reset request pulse |

## Verification
Every valid mode code is written with a clear, and the timing of the first and second ticks is measured. This separates a wrong tap from a wrong restart point. Reserved codes are written after a known selection, which shows that no stale or partial decode is taken. Stop releases are tried with each source, and with both sources together, under mode selections whose interval differs from the fixed reset interval. A hold length that matches the mode exposes a source mix-up. Random rounds interleave mode writes, watchdog enables and stop/release cycles, and the settling length and the following tick phase are checked after each.

// File: rtl/bit_pkg.sv
package bit_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAIT = 2'd2
    } bit_state_e;

    localparam int NTAP = 4;

    localparam logic [2:0] CODE_M0 = 3'b000;
    localparam logic [2:0] CODE_M3 = 3'b011;
    localparam logic [2:0] CODE_M5 = 3'b101;
    localparam logic [2:0] CODE_M7 = 3'b111;

endpackage

// File: rtl/bit_mode_reg.sv
module bit_mode_reg
    import bit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] code,
    input  logic       wd_in,
    output logic [1:0] idx,
    output logic       wd_en
);

    typedef struct packed {
        logic [1:0] idx;
        logic       wd;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (we) begin
            mode_d.wd = wd_in;
            case (code)
                CODE_M0: mode_d.idx = 2'd0;
                CODE_M3: mode_d.idx = 2'd1;
                CODE_M5: mode_d.idx = 2'd2;
                CODE_M7: mode_d.idx = 2'd3;
                default: mode_d.idx = mode_q.idx;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign idx   = mode_q.idx;
    assign wd_en = mode_q.wd;

endmodule

// File: rtl/bit_taps.sv
module bit_taps
    import bit_pkg::*;
#(
    parameter int SH_M0  = 20,
    parameter int SH_M3  = 17,
    parameter int SH_M5  = 15,
    parameter int SH_M7  = 13,
    parameter int SH_RST = 17,
    parameter int CW     = SH_M0
) (
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    idx,
    output logic          sel_hit,
    output logic          rst_hit
);

    localparam int SHS [NTAP] = '{SH_M0, SH_M3, SH_M5, SH_M7};

    logic [NTAP-1:0] hit;

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign hit[g] = &cnt[SHS[g]-1:0];
    end

    assign sel_hit = hit[idx];
    assign rst_hit = &cnt[SH_RST-1:0];

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import bit_pkg::*;
#(
    parameter int SH_M0  = 20,
    parameter int SH_M3  = 17,
    parameter int SH_M5  = 15,
    parameter int SH_M7  = 13,
    parameter int SH_RST = 17,
    parameter int CW     = SH_M0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_wdog,
    input  logic       cfg_clr,
    input  logic       stop_req,
    input  logic       wake_rst,
    input  logic       wake_irq,
    output logic       cpu_hold,
    output logic       tick_irq,
    output logic       wdt_rst
);

    typedef struct packed {
        bit_state_e    st;
        logic          use_rst;
        logic [CW-1:0] cnt;
        logic          tick;
        logic          wdt;
    } core_t;

    core_t q_d, q_q;

    logic [1:0] idx;
    logic       wd_en;
    logic       sel_hit;
    logic       rst_hit;
    logic       clr_now;

    bit_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .code  (cfg_mode),
        .wd_in (cfg_wdog),
        .idx   (idx),
        .wd_en (wd_en)
    );

    bit_taps #(
        .SH_M0  (SH_M0),
        .SH_M3  (SH_M3),
        .SH_M5  (SH_M5),
        .SH_M7  (SH_M7),
        .SH_RST (SH_RST),
        .CW     (CW)
    ) u_taps (
        .cnt     (q_q.cnt),
        .idx     (idx),
        .sel_hit (sel_hit),
        .rst_hit (rst_hit)
    );

    assign clr_now = cfg_we && cfg_clr;

    always_comb begin
        q_d      = q_q;
        q_d.tick = 1'b0;
        q_d.wdt  = 1'b0;
        case (q_q.st)
            ST_RUN: begin
                q_d.cnt  = clr_now ? '0 : q_q.cnt + 1'b1;
                q_d.tick = sel_hit && !clr_now && !stop_req;
                q_d.wdt  = sel_hit && !clr_now && !stop_req && wd_en;
                if (stop_req) begin
                    q_d.st = ST_STOP;
                end
            end
            ST_STOP: begin
                // oscillator idle: counter frozen until a release
                if (wake_rst || wake_irq) begin
                    q_d.st      = ST_WAIT;
                    q_d.use_rst = wake_rst;
                    q_d.cnt     = '0;
                end
            end
            ST_WAIT: begin
                q_d.cnt = q_q.cnt + 1'b1;
                if (q_q.use_rst ? rst_hit : sel_hit) begin
                    q_d.st = ST_RUN;
                end
            end
            default: begin
                q_d.st = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: ST_RUN, use_rst: 1'b0, cnt: '0, tick: 1'b0, wdt: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign cpu_hold = (q_q.st != ST_RUN);
    assign tick_irq = q_q.tick;
    assign wdt_rst  = q_q.wdt;

    logic          stopped;
    logic [CW-1:0] cnt_now;
    assign stopped = (q_q.st == ST_STOP);
    assign cnt_now = q_q.cnt;

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
    parameter int CW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_mode,
    input logic          cfg_clr,
    input logic          stop_req,
    input logic          wake_rst,
    input logic          wake_irq,
    input logic          cpu_hold,
    input logic          tick_irq,
    input logic          wdt_rst,
    input logic          stopped,
    input logic [CW-1:0] cnt,
    input logic [1:0]    idx
);

    logic reserved;
    assign reserved = !(cfg_mode inside {3'b000, 3'b011, 3'b101, 3'b111});

    // R10
    tick_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> !$past(cpu_hold));

    // R5
    wdt_with_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> tick_irq);

    // R2
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq);

    // R6
    stop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_hold && stop_req) |=> (cpu_hold && stopped));

    // R6
    stop_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !wake_rst && !wake_irq) |=> $stable(cnt));

    // R7
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && (wake_rst || wake_irq)) |=> (cpu_hold && !stopped && cnt == '0));

    // R3
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && reserved) |=> $stable(idx));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_hold && cfg_we && cfg_clr && !stop_req) |=> (cnt == '0 && !tick_irq));

endmodule

bind interval_timer interval_timer_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .cfg_clr  (cfg_clr),
    .stop_req (stop_req),
    .wake_rst (wake_rst),
    .wake_irq (wake_irq),
    .cpu_hold (cpu_hold),
    .tick_irq (tick_irq),
    .wdt_rst  (wdt_rst),
    .stopped  (stopped),
    .cnt      (cnt_now),
    .idx      (idx)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;

    localparam int SH_M0  = 10;
    localparam int SH_M3  = 8;
    localparam int SH_M5  = 6;
    localparam int SH_M7  = 4;
    localparam int SH_RST = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_mode = 3'b000;
    logic       cfg_wdog = 1'b0;
    logic       cfg_clr = 1'b0;
    logic       stop_req = 1'b0;
    logic       wake_rst = 1'b0;
    logic       wake_irq = 1'b0;
    logic       cpu_hold, tick_irq, wdt_rst;

    int  n_vec = 0;
    int  n_bad = 0;
    int  cur_sh = SH_M0;
    bit  cur_wd = 1'b0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    interval_timer #(
        .SH_M0(SH_M0), .SH_M3(SH_M3), .SH_M5(SH_M5), .SH_M7(SH_M7), .SH_RST(SH_RST)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_wdog(cfg_wdog), .cfg_clr(cfg_clr), .stop_req(stop_req),
        .wake_rst(wake_rst), .wake_irq(wake_irq),
        .cpu_hold(cpu_hold), .tick_irq(tick_irq), .wdt_rst(wdt_rst)
    );

    function automatic int code_sh(logic [2:0] c);
        case (c)
            3'b000:  return SH_M0;
            3'b011:  return SH_M3;
            3'b101:  return SH_M5;
            3'b111:  return SH_M7;
            default: return -1;
        endcase
    endfunction

    // first tick edge counted from a release edge, given the hold length
    function automatic int next_tick(int hold, int s);
        return ((hold >> s) + 1) << s;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(logic [2:0] code, bit wd, bit clr);
        cfg_we = 1'b1; cfg_mode = code; cfg_wdog = wd; cfg_clr = clr;
        @(negedge clk);
        cfg_we = 1'b0; cfg_clr = 1'b0;
        if (code_sh(code) > 0) cur_sh = code_sh(code);
        cur_wd = wd;
    endtask

    // waits for the first tick after the last edge; expects it exp edges later
    task automatic run_tick(int exp, string req);
        int got = 0;
        bit wd_seen = 1'b0;
        for (int j = 1; j <= 2 * exp + 4; j++) begin
            @(negedge clk);
            if (wdt_rst && !tick_irq) wd_seen = 1'b1;
            if (tick_irq) begin
                got = j;
                if (wdt_rst != cur_wd) wd_seen = 1'b1;
                break;
            end
        end
        check(got == exp, req, got, exp);
        check(!wd_seen, "R5 wdt_rst pairing", wd_seen, 0);
    endtask

    task automatic do_stop(int dwell);
        bit bad = 1'b0;
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        for (int j = 0; j < dwell; j++) begin
            if (!cpu_hold || tick_irq || wdt_rst) bad = 1'b1;
            @(negedge clk);
        end
        if (!cpu_hold || tick_irq || wdt_rst) bad = 1'b1;
        check(!bad, "R6 stop holds and is silent", bad, 0);
    endtask

    // release, measure hold, then measure following tick
    task automatic do_wake(bit r, bit i, string req);
        int exp_hold = r ? (1 << SH_RST) : (1 << cur_sh);
        int got = 0;
        bit ticked = 1'b0;
        wake_rst = r; wake_irq = i;
        @(negedge clk);
        wake_rst = 1'b0; wake_irq = 1'b0;
        for (int j = 1; j <= exp_hold + 4; j++) begin
            if (j > 1 && tick_irq) ticked = 1'b1;
            if (!cpu_hold) begin
                got = j - 1;
                break;
            end
            @(negedge clk);
        end
        check(got == exp_hold, req, got, exp_hold);
        check(!ticked, "R10 no tick while held", ticked, 0);
        run_tick(next_tick(exp_hold, cur_sh) - exp_hold, "R10 tick phase after wait");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(!cpu_hold && !tick_irq && !wdt_rst, "R1 outputs in reset",
              {cpu_hold, tick_irq, wdt_rst}, 0);
        rst_n = 1'b1;
        run_tick(1 << SH_M0, "R1 default interval");

        // R2 each valid code, first and second tick
        cfg(3'b011, 1'b0, 1'b1); run_tick(1 << SH_M3, "R2 code 011");
        run_tick(1 << SH_M3, "R2 code 011 period");
        cfg(3'b101, 1'b0, 1'b1); run_tick(1 << SH_M5, "R2 code 101");
        cfg(3'b111, 1'b0, 1'b1); run_tick(1 << SH_M7, "R2 code 111");
        run_tick(1 << SH_M7, "R2 code 111 period");
        cfg(3'b000, 1'b0, 1'b1); run_tick(1 << SH_M0, "R2 code 000");

        // R3 reserved codes keep previous selection
        cfg(3'b111, 1'b0, 1'b1);
        cfg(3'b110, 1'b0, 1'b1); run_tick(1 << SH_M7, "R3 code 110 ignored");
        cfg(3'b101, 1'b0, 1'b1);
        cfg(3'b001, 1'b0, 1'b1); run_tick(1 << SH_M5, "R3 code 001 ignored");
        cfg(3'b010, 1'b0, 1'b1); run_tick(1 << SH_M5, "R3 code 010 ignored");
        cfg(3'b100, 1'b0, 1'b1); run_tick(1 << SH_M5, "R3 code 100 ignored");

        // R4 / R5 repeated clears keep watchdog quiet
        cfg(3'b111, 1'b1, 1'b1);
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 6; k++) begin
                for (int j = 0; j < 12; j++) begin
                    @(negedge clk);
                    if (tick_irq || wdt_rst) seen = 1'b1;
                end
                cfg(3'b111, 1'b1, 1'b1);
                if (tick_irq || wdt_rst) seen = 1'b1;
            end
            check(!seen, "R4 clear restarts before overflow", seen, 0);
        end
        run_tick(1 << SH_M7, "R5 watchdog fires on overflow");
        cfg(3'b111, 1'b0, 1'b1); run_tick(1 << SH_M7, "R5 disabled watchdog silent");

        // R8 interrupt release uses selected interval
        cfg(3'b101, 1'b0, 1'b1);
        do_stop(30);
        do_wake(1'b0, 1'b1, "R8 interrupt release hold");
        // R7 reset release uses fixed interval, independent of mode
        cfg(3'b000, 1'b0, 1'b1);
        do_stop(7);
        do_wake(1'b1, 1'b0, "R7 reset release hold");
        // R9 both sources together
        cfg(3'b111, 1'b1, 1'b1);
        do_stop(3);
        do_wake(1'b1, 1'b1, "R9 both sources: reset wins");

        // random rounds
        for (int it = 0; it < 24; it++) begin
            logic [2:0] code = 3'($urandom % 8);
            bit wd = 1'($urandom % 2);
            cfg(code, wd, 1'b1);
            if ($urandom % 3 == 0) begin
                int src = int'($urandom % 3);
                do_stop(1 + int'($urandom % 40));
                if (src == 0)      do_wake(1'b1, 1'b0, "R7 random reset release");
                else if (src == 1) do_wake(1'b0, 1'b1, "R8 random interrupt release");
                else               do_wake(1'b1, 1'b1, "R9 random dual release");
            end else begin
                run_tick(1 << cur_sh, "R2 random mode tick");
                run_tick(1 << cur_sh, "R2 random mode period");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule